// File: doc/BRIEF.md
# Receive DC Offset Compensator

This block removes a constant additive offset from a complex baseband receive stream. Each sample arrives as a signed in-phase value and a signed quadrature value, qualified by a valid strobe. If the observed sample is the true sample plus a fixed error D, the block adds a correction close to minus D. The two rails are corrected independently.

Two modes are chosen by a single control bit. In manual mode a programmed signed correction value, one per rail, is added to each sample. In automatic mode a single-tap feedback IIR filter acts as a notch at DC. It keeps a wide accumulator per rail that gains the previous output scaled by 2^-20, and the accumulator's integer part is subtracted from each new input. The 2^-20 scaling is done with a shift, not a multiply. Every result is clamped to the 16-bit signed range. The results are registered, so the output follows the input by one clock cycle.

Top module: `rxdc_comp`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_i` and `out_q` become 0 and both accumulators are cleared.
- R2: `out_valid` at each rising edge takes the value that `in_valid` had at the previous rising edge (latency of one cycle).
- R3: In manual mode (`auto_en` = 0), a valid input gives, one cycle later, `out_i` = clamp(`in_i` + `corr_i`) and `out_q` = clamp(`in_q` + `corr_q`), all values 16-bit two's complement.
- R4: The clamp maps any result above 32767 to 32767 (0x7FFF) and any result below -32768 to -32768 (0x8000), and never wraps.
- R5: In automatic mode (`auto_en` = 1), each rail keeps an accumulator A with 20 fractional bits. A valid input x gives, one cycle later, y = clamp(x - floor(A / 2^20)), and A then becomes A + y. The correction inputs have no effect in this mode.
- R6: When `auto_en` is 1 at a rising edge and was 0 (or reset was active) at the previous edge, both accumulators are treated as 0 for that edge. A valid sample in that cycle is therefore passed through unchanged (clamp(x - 0) = x).
- R7: When `in_valid` is low, `out_i` and `out_q` hold their values and the accumulators do not change.
- R8: The in-phase and quadrature accumulators evolve independently. Each depends only on its own rail's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| auto_en | input | 1 | 1 selects automatic DC notch, 0 selects manual correction |
| corr_i | input | 16 | Manual in-phase correction value, signed |
| corr_q | input | 16 | Manual quadrature correction value, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Corrected in-phase sample, signed |
| out_q | output | 16 | Corrected quadrature sample, signed |

## Verification
The assertions assume that the inputs are steady around each rising edge and that `auto_en` changes only at clock edges. Under that assumption, a rise of `auto_en` seen one edge earlier is the same event that the design treats as mode entry. The manual-mode and saturation properties assume that the correction values are sampled at the same edge as the data. The stimulus changes every input only on falling edges. It also toggles the mode rarely, so that long automatic runs build up a non-zero accumulator integer part before the next mode entry clears it.

// File: rtl/rxdc_pkg.sv
package rxdc_pkg;
    localparam int SMP_W       = 16;
    localparam int ALPHA_SHIFT = 20;
    localparam int ACC_GUARD   = 2;
    localparam int NUM_RAILS   = 2;

    typedef logic signed [SMP_W-1:0] smp_t;

    localparam smp_t SMP_HI = {1'b0, {(SMP_W-1){1'b1}}};
    localparam smp_t SMP_LO = {1'b1, {(SMP_W-1){1'b0}}};

    typedef struct packed {
        smp_t i;
        smp_t q;
    } iq_t;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } mode_e;
endpackage

// File: rtl/rxdc_ctrl.sv
module rxdc_ctrl
    import rxdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  auto_en,
    output mode_e mode,
    output logic  acc_clr,
    output logic  valid_q
);
    mode_e mode_q;

    always_comb begin
        mode    = auto_en ? MODE_AUTO : MODE_MANUAL;
        acc_clr = (mode == MODE_AUTO) && (mode_q == MODE_MANUAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_MANUAL;
            valid_q <= 1'b0;
        end else begin
            mode_q  <= mode;
            valid_q <= in_valid;
        end
    end
endmodule

// File: rtl/rxdc_rail.sv
module rxdc_rail
    import rxdc_pkg::*;
#(
    parameter int SHIFT_BITS = ALPHA_SHIFT,
    parameter int GUARD_BITS = ACC_GUARD
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  mode_e mode,
    input  logic  acc_clr,
    input  smp_t  x,
    input  smp_t  corr,
    output smp_t  y
);
    localparam int ACC_W = SMP_W + SHIFT_BITS + GUARD_BITS;
    localparam int INT_W = ACC_W - SHIFT_BITS;
    localparam int EXT_W = INT_W + 1;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [EXT_W-1:0] ext_t;

    localparam ext_t EXT_HI = EXT_W'(SMP_HI);
    localparam ext_t EXT_LO = EXT_W'(SMP_LO);

    acc_t                    acc_q;
    acc_t                    acc_eff;
    acc_t                    acc_nxt;
    logic signed [INT_W-1:0] acc_int;
    ext_t                    sum_man;
    ext_t                    sum_auto;
    ext_t                    pick;
    smp_t                    y_d;

    always_comb begin
        acc_eff  = acc_clr ? '0 : acc_q;
        acc_int  = acc_eff[ACC_W-1:SHIFT_BITS];
        sum_man  = EXT_W'(x) + EXT_W'(corr);
        sum_auto = EXT_W'(x) - EXT_W'(acc_int);
        pick     = (mode == MODE_AUTO) ? sum_auto : sum_man;
        if (pick > EXT_HI) begin
            y_d = SMP_HI;
        end else if (pick < EXT_LO) begin
            y_d = SMP_LO;
        end else begin
            y_d = pick[SMP_W-1:0];
        end
        acc_nxt = acc_eff + ACC_W'(y_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            y     <= '0;
        end else begin
            if (vld) begin
                y <= y_d;
            end
            if (vld && (mode == MODE_AUTO)) begin
                acc_q <= acc_nxt;
            end else if (acc_clr) begin
                acc_q <= '0;
            end
        end
    end
endmodule

// File: rtl/rxdc_comp.sv
module rxdc_comp
    import rxdc_pkg::*;
#(
    parameter int SHIFT_BITS = ALPHA_SHIFT,
    parameter int GUARD_BITS = ACC_GUARD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_i,
    input  logic signed [SMP_W-1:0] in_q,
    input  logic                    auto_en,
    input  logic signed [SMP_W-1:0] corr_i,
    input  logic signed [SMP_W-1:0] corr_q,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_i,
    output logic signed [SMP_W-1:0] out_q
);
    mode_e mode;
    logic  acc_clr;
    iq_t   smp_in;
    iq_t   smp_corr;
    iq_t   smp_out;
    smp_t  rail_x    [NUM_RAILS];
    smp_t  rail_corr [NUM_RAILS];
    smp_t  rail_y    [NUM_RAILS];

    rxdc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .auto_en  (auto_en),
        .mode     (mode),
        .acc_clr  (acc_clr),
        .valid_q  (out_valid)
    );

    always_comb begin
        smp_in    = '{i: in_i, q: in_q};
        smp_corr  = '{i: corr_i, q: corr_q};
        rail_x[0]    = smp_in.i;
        rail_x[1]    = smp_in.q;
        rail_corr[0] = smp_corr.i;
        rail_corr[1] = smp_corr.q;
        smp_out   = '{i: rail_y[0], q: rail_y[1]};
        out_i     = smp_out.i;
        out_q     = smp_out.q;
    end

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        rxdc_rail #(
            .SHIFT_BITS (SHIFT_BITS),
            .GUARD_BITS (GUARD_BITS)
        ) u_rail (
            .clk     (clk),
            .rst     (rst),
            .vld     (in_valid),
            .mode    (mode),
            .acc_clr (acc_clr),
            .x       (rail_x[r]),
            .corr    (rail_corr[r]),
            .y       (rail_y[r])
        );
    end
endmodule

// File: rtl/rxdc_comp_chk.sv
module rxdc_comp_chk (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic signed [15:0] in_i,
    input logic signed [15:0] in_q,
    input logic               auto_en,
    input logic signed [15:0] corr_i,
    input logic signed [15:0] corr_q,
    input logic               out_valid,
    input logic signed [15:0] out_i,
    input logic signed [15:0] out_q
);
    logic signed [16:0] man_i;
    logic signed [16:0] man_q;

    always_comb begin
        man_i = 17'(in_i) + 17'(corr_i);
        man_q = 17'(in_q) + 17'(corr_q);
    end

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_i == 16'sd0 && out_q == 16'sd0));

    // R2: one-cycle valid latency
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R7: outputs hold without a valid input
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    // R3: manual sum within range appears one cycle later
    assert_manual_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !auto_en && man_i <= 17'sd32767 && man_i >= -17'sd32768)
        |=> (out_i == $past(man_i[15:0])));

    // R4: positive and negative clamp in manual mode
    assert_sat_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !auto_en && man_q > 17'sd32767) |=> (out_q == 16'sh7fff));
    assert_sat_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !auto_en && man_i < -17'sd32768) |=> (out_i == 16'sh8000));

    // R6: first valid sample after entering automatic mode passes through
    assert_auto_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && auto_en && !$past(auto_en))
        |=> (out_i == $past(in_i) && out_q == $past(in_q)));
endmodule

bind rxdc_comp rxdc_comp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .auto_en   (auto_en),
    .corr_i    (corr_i),
    .corr_q    (corr_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_rxdc_comp.sv
`timescale 1ns/1ps
module sim_rxdc_comp;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               auto_en = 1'b0;
    logic signed [15:0] corr_i = '0;
    logic signed [15:0] corr_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    longint acc_ri = 0;
    longint acc_rq = 0;
    bit     prev_auto = 1'b0;
    int     exp_i = 0;
    int     exp_q = 0;
    bit     exp_v = 1'b0;

    always #10 clk = ~clk;

    rxdc_comp u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .auto_en(auto_en), .corr_i(corr_i), .corr_q(corr_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int clamp16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic check(string tag, longint act, longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic ref_step(bit v, int xi, int xq, bit a, int ci, int cq);
        bit     clr;
        longint ei;
        longint eq;
        clr = a && !prev_auto;
        ei  = clr ? 0 : acc_ri;
        eq  = clr ? 0 : acc_rq;
        if (v) begin
            if (a) begin
                exp_i = clamp16(longint'(xi) - (ei >>> 20));
                exp_q = clamp16(longint'(xq) - (eq >>> 20));
                ei    = ei + exp_i;
                eq    = eq + exp_q;
            end else begin
                exp_i = clamp16(longint'(xi) + ci);
                exp_q = clamp16(longint'(xq) + cq);
            end
        end
        acc_ri    = ei;
        acc_rq    = eq;
        prev_auto = a;
        exp_v     = v;
    endtask

    // drive at falling edge, check 5 ns after the rising edge
    task automatic step(bit v, int xi, int xq, bit a, int ci, int cq, string tag);
        @(negedge clk);
        in_valid = v; in_i = 16'(xi); in_q = 16'(xq);
        auto_en = a; corr_i = 16'(ci); corr_q = 16'(cq);
        ref_step(v, xi, xq, a, ci, cq);
        @(posedge clk);
        #5;
        check({tag, " valid (R2)"}, longint'(out_valid), longint'(exp_v));
        check({tag, " i"}, longint'(out_i), longint'(exp_i));
        check({tag, " q"}, longint'(out_q), longint'(exp_q));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int xi;
        int xq;
        bit a;
        int ci;
        int cq;
        seed = 32'h1d5c0ffe;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #5;
        check("R1 reset valid", longint'(out_valid), 0);
        check("R1 reset i", longint'(out_i), 0);
        check("R1 reset q", longint'(out_q), 0);
        @(negedge clk);
        rst = 1'b0;

        // manual mode, plain sums
        step(1, 100, -200, 0, -30, 45, "R3 manual sum");
        step(1, -5000, 7000, 0, 1234, -4321, "R3 manual sum2");
        // clamp both directions
        step(1, 32000, -32000, 0, 1000, -1000, "R4 clamp");
        step(1, -32768, 32767, 0, -1, 1, "R4 clamp edge");
        step(1, 32767, -32768, 0, 0, 0, "R4 no clamp");
        // invalid cycles: outputs hold
        step(0, 111, 222, 0, 333, 444, "R7 hold manual");
        step(0, -9, 9, 0, 0, 0, "R7 hold manual2");

        // automatic mode: entry passes through, then accumulate
        step(1, 20000, -15000, 1, 999, 999, "R6 auto entry");
        for (int k = 0; k < 300; k++) begin
            step(1, 20000 + (k % 7), -15000 - (k % 5), 1, k, -k, "R5 auto track R8");
            if (k % 50 == 0) step(0, 1, 1, 1, 0, 0, "R7 hold auto");
        end
        // second entry after manual interlude
        step(1, 10, 20, 0, 5, 5, "R3 manual interlude");
        step(0, 0, 0, 0, 0, 0, "R7 idle");
        step(0, 0, 0, 1, 0, 0, "R6 entry idle");
        step(1, 3000, 4000, 1, 0, 0, "R6 after idle entry");
        step(1, 12345, -12345, 0, 0, 0, "R3 back manual");
        step(1, 31000, -31000, 1, 0, 0, "R6 reentry");

        // constrained random mix
        a = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            if (($urandom() % 200) == 0) a = ~a;
            xi = int'($urandom() % 65536) - 32768;
            xq = int'($urandom() % 65536) - 32768;
            if (($urandom() % 4) == 0) begin
                xi = 30000 + int'($urandom() % 2768);
                xq = -30000 - int'($urandom() % 2768);
            end
            ci = int'($urandom() % 8192) - 4096;
            cq = int'($urandom() % 8192) - 4096;
            step(($urandom() % 5) != 0, xi, xq, a, ci, cq, a ? "R5 random auto" : "R3 random manual");
        end

        // reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R1 mid reset valid", longint'(out_valid), 0);
        check("R1 mid reset i", longint'(out_i), 0);
        @(negedge clk);
        rst = 1'b0;
        acc_ri = 0; acc_rq = 0; prev_auto = 1'b0; exp_i = 0; exp_q = 0;
        step(1, -123, 456, 1, 0, 0, "R1 auto after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule